// File: doc/BRIEF.md
# Interrupt Return State Restore Unit

This block carries out the return-from-interrupt step of a small processor core. When the core issues a one-cycle return strobe with a 3-bit return-kind code, the unit selects the saved address/state pair that belongs to that kind. It clears the bits of the saved state word that the kind may not restore, and sizes both values for 32-bit or 64-bit operation. It then writes the program counter and the machine-state register on the same clock edge. One cycle after that edge it raises a single-cycle redirect pulse, which tells fetch to drop the current instruction block and resume at the new address.

The control is a two-state machine. `ST_IDLE` waits for a strobe. `ST_REDIRECT` is the cycle in which the redirect pulse is high. The transition *accept* (ST_IDLE to ST_REDIRECT) fires on a strobe. The transition *chain* (ST_REDIRECT to ST_REDIRECT) fires on a strobe that arrives while a pulse is already high. The transition *settle* (ST_REDIRECT to ST_IDLE) fires when no strobe is present.

The 64-bit mode test uses the most significant bit of the raw saved state word, read before masking. For the plain normal return only, the upper half of the block's own current state register is kept when that bit is clear. Privilege checking and fetch are handled elsewhere.

Top module: `irq_return_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` and `state_o` are cleared to zero and `flush_o` is low.
- R2: The edge that samples `ret_valid` high loads `pc_o` with the selected saved address with bits [1:0] forced to 0.
- R3: The return-kind codes select these sources. 0 is normal and 1 is wide-normal, both using `srr_*`. 2 is hypervisor (`hsrr_*`). 3 is the older embedded critical kind (`ecrit_*`). 4 is critical (`crit_*`). 5 is debug (`dbg_*`). 6 is machine-check (`mchk_*`). 7 is the legacy kind, which takes its address from `link_reg` and its state from `count_reg`.
- R4: The saved state word is ANDed with a mask chosen by kind. Kinds 0, 1 and 2 clear the bits of 0x783F0000. Kind 3 clears 0xFFFF0000. Kinds 4, 5 and 6 clear 0x3FFF0000. Kind 7 keeps only bits [15:0].
- R5: When bit 63 of the raw saved state word is 1, the full 64-bit aligned address and the full 64-bit masked state are loaded.
- R6: When bit 63 of the raw saved state word is 0, both values are truncated to their low 32 bits, so the upper halves become zero. The exception is kind 0, which instead keeps the upper 32 bits of the current `state_o`.
- R7: `flush_o` is high for exactly the one cycle after each accepted strobe. Strobes on consecutive cycles keep it high for the same number of consecutive cycles.
- R8: In a cycle where `ret_valid` is low, `pc_o` and `state_o` hold their values whatever the saved-register inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | One-cycle return strobe |
| ret_kind | input | 3 | Return-kind code |
| srr_addr | input | 64 | Normal saved address |
| srr_state | input | 64 | Normal saved state |
| hsrr_addr | input | 64 | Hypervisor saved address |
| hsrr_state | input | 64 | Hypervisor saved state |
| ecrit_addr | input | 64 | Older embedded critical saved address |
| ecrit_state | input | 64 | Older embedded critical saved state |
| crit_addr | input | 64 | Critical saved address |
| crit_state | input | 64 | Critical saved state |
| dbg_addr | input | 64 | Debug saved address |
| dbg_state | input | 64 | Debug saved state |
| mchk_addr | input | 64 | Machine-check saved address |
| mchk_state | input | 64 | Machine-check saved state |
| link_reg | input | 64 | Link register, the legacy address source |
| count_reg | input | 64 | Count register, the legacy state source |
| pc_o | output | 64 | Program counter |
| state_o | output | 64 | Machine-state register |
| flush_o | output | 1 | Redirect pulse |

## Verification
A wrong source selection or mask shows up at `pc_o` or `state_o` on the very edge that accepts the strobe, so each vector is compared one cycle after it is driven. A kind-0 return is run both after a state with its upper half set and after one with its upper half clear, so that a missing or misapplied keep of the upper half is visible. A redirect machine stuck in the wrong state shows up on `flush_o` within one cycle: the pulse is missing, it lasts two cycles, or it does not extend across back-to-back strobes.

// File: rtl/irq_ret_pkg.sv
package irq_ret_pkg;

    typedef enum logic [2:0] {
        RK_NORMAL   = 3'd0,
        RK_WIDE     = 3'd1,
        RK_HYPER    = 3'd2,
        RK_ECRIT    = 3'd3,
        RK_CRIT     = 3'd4,
        RK_DEBUG    = 3'd5,
        RK_MCHK     = 3'd6,
        RK_LEGACY   = 3'd7
    } ret_kind_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_REDIRECT = 1'b1
    } ret_fsm_e;

endpackage

// File: rtl/ret_src_sel.sv
module ret_src_sel
    import irq_ret_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  ret_kind_e        kind,
    input  logic [XLEN-1:0]  srr_addr,
    input  logic [XLEN-1:0]  srr_state,
    input  logic [XLEN-1:0]  hsrr_addr,
    input  logic [XLEN-1:0]  hsrr_state,
    input  logic [XLEN-1:0]  ecrit_addr,
    input  logic [XLEN-1:0]  ecrit_state,
    input  logic [XLEN-1:0]  crit_addr,
    input  logic [XLEN-1:0]  crit_state,
    input  logic [XLEN-1:0]  dbg_addr,
    input  logic [XLEN-1:0]  dbg_state,
    input  logic [XLEN-1:0]  mchk_addr,
    input  logic [XLEN-1:0]  mchk_state,
    input  logic [XLEN-1:0]  link_reg,
    input  logic [XLEN-1:0]  count_reg,
    output logic [XLEN-1:0]  sel_addr,
    output logic [XLEN-1:0]  sel_state
);

    // R3: pick the saved pair that belongs to the return kind
    always_comb begin
        unique case (kind)
            RK_NORMAL, RK_WIDE: begin sel_addr = srr_addr;   sel_state = srr_state;   end
            RK_HYPER:           begin sel_addr = hsrr_addr;  sel_state = hsrr_state;  end
            RK_ECRIT:           begin sel_addr = ecrit_addr; sel_state = ecrit_state; end
            RK_CRIT:            begin sel_addr = crit_addr;  sel_state = crit_state;  end
            RK_DEBUG:           begin sel_addr = dbg_addr;   sel_state = dbg_state;   end
            RK_MCHK:            begin sel_addr = mchk_addr;  sel_state = mchk_state;  end
            RK_LEGACY:          begin sel_addr = link_reg;   sel_state = count_reg;   end
            default:            begin sel_addr = srr_addr;   sel_state = srr_state;   end
        endcase
    end

endmodule

// File: rtl/ret_state_fmt.sv
module ret_state_fmt
    import irq_ret_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  ret_kind_e          kind,
    input  logic [XLEN-1:0]    raw_addr,
    input  logic [XLEN-1:0]    raw_state,
    input  logic [XLEN/2-1:0]  cur_hi,
    output logic [XLEN-1:0]    next_pc,
    output logic [XLEN-1:0]    next_state
);

    localparam int HALF = XLEN / 2;
    localparam logic [XLEN-1:0] M_STD    = ~XLEN'(32'h783F_0000);
    localparam logic [XLEN-1:0] M_ECRIT  = ~XLEN'(32'hFFFF_0000);
    localparam logic [XLEN-1:0] M_BOOK   = ~XLEN'(32'h3FFF_0000);
    localparam logic [XLEN-1:0] M_LEGACY =  XLEN'(32'h0000_FFFF);

    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] masked;

    // R4: per-kind mask on the saved state word
    always_comb begin
        unique case (kind)
            RK_NORMAL, RK_WIDE, RK_HYPER: mask = M_STD;
            RK_ECRIT:                     mask = M_ECRIT;
            RK_CRIT, RK_DEBUG, RK_MCHK:   mask = M_BOOK;
            RK_LEGACY:                    mask = M_LEGACY;
            default:                      mask = M_STD;
        endcase
    end

    assign masked = raw_state & mask;

    generate
        if (XLEN == 64) begin : g_wide
            logic wide_mode;
            assign wide_mode = raw_state[XLEN-1];
            // R5 / R6: width handling driven by the raw mode bit
            always_comb begin
                if (wide_mode) begin
                    next_pc    = {raw_addr[XLEN-1:2], 2'b00};
                    next_state = masked;
                end else begin
                    next_pc    = {{HALF{1'b0}}, raw_addr[HALF-1:2], 2'b00};
                    next_state = {(kind == RK_NORMAL) ? cur_hi : {HALF{1'b0}},
                                  masked[HALF-1:0]};
                end
            end
        end else begin : g_narrow
            assign next_pc    = {raw_addr[XLEN-1:2], 2'b00};
            assign next_state = masked;
        end
    endgenerate

endmodule

// File: rtl/irq_return_unit.sv
module irq_return_unit
    import irq_ret_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic [2:0]        ret_kind,
    input  logic [XLEN-1:0]   srr_addr,
    input  logic [XLEN-1:0]   srr_state,
    input  logic [XLEN-1:0]   hsrr_addr,
    input  logic [XLEN-1:0]   hsrr_state,
    input  logic [XLEN-1:0]   ecrit_addr,
    input  logic [XLEN-1:0]   ecrit_state,
    input  logic [XLEN-1:0]   crit_addr,
    input  logic [XLEN-1:0]   crit_state,
    input  logic [XLEN-1:0]   dbg_addr,
    input  logic [XLEN-1:0]   dbg_state,
    input  logic [XLEN-1:0]   mchk_addr,
    input  logic [XLEN-1:0]   mchk_state,
    input  logic [XLEN-1:0]   link_reg,
    input  logic [XLEN-1:0]   count_reg,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   state_o,
    output logic              flush_o
);

    localparam int HALF = XLEN / 2;

    ret_kind_e       kind;
    ret_fsm_e        fsm_q, fsm_d;
    logic [XLEN-1:0] src_addr, src_state;
    logic [XLEN-1:0] nxt_pc, nxt_state;
    logic [XLEN-1:0] pc_q, state_q;

    assign kind = ret_kind_e'(ret_kind);

    ret_src_sel #(.XLEN(XLEN)) u_sel (
        .kind        (kind),
        .srr_addr    (srr_addr),
        .srr_state   (srr_state),
        .hsrr_addr   (hsrr_addr),
        .hsrr_state  (hsrr_state),
        .ecrit_addr  (ecrit_addr),
        .ecrit_state (ecrit_state),
        .crit_addr   (crit_addr),
        .crit_state  (crit_state),
        .dbg_addr    (dbg_addr),
        .dbg_state   (dbg_state),
        .mchk_addr   (mchk_addr),
        .mchk_state  (mchk_state),
        .link_reg    (link_reg),
        .count_reg   (count_reg),
        .sel_addr    (src_addr),
        .sel_state   (src_state)
    );

    ret_state_fmt #(.XLEN(XLEN)) u_fmt (
        .kind       (kind),
        .raw_addr   (src_addr),
        .raw_state  (src_state),
        .cur_hi     (state_q[XLEN-1:HALF]),
        .next_pc    (nxt_pc),
        .next_state (nxt_state)
    );

    // Next-state logic: accept, chain, settle
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_IDLE:     if (ret_valid) fsm_d = ST_REDIRECT;
            ST_REDIRECT: fsm_d = ret_valid ? ST_REDIRECT : ST_IDLE;
            default:     fsm_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= ST_IDLE;
        else        fsm_q <= fsm_d;
    end

    // Architected registers (R1, R2, R8)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            state_q <= '0;
        end else if (ret_valid) begin
            pc_q    <= nxt_pc;
            state_q <= nxt_state;
        end
    end

    // Outputs
    always_comb begin
        pc_o    = pc_q;
        state_o = state_q;
        flush_o = (fsm_q == ST_REDIRECT);
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && state_o == '0 && !flush_o));

    a_r2_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> (pc_o[1:0] == 2'b00));

    a_r7_flush_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> flush_o);

    a_r7_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |=> !flush_o);

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |=> ($stable(pc_o) && $stable(state_o)));

    generate
        if (XLEN == 64) begin : g_chk
            a_r6_narrow_pc: assert property (@(posedge clk) disable iff (!rst_n)
                (ret_valid && !src_state[XLEN-1]) |=> (pc_o[XLEN-1:HALF] == '0));
        end
    endgenerate

endmodule

// File: tb/irq_return_unit_tb_top.sv
module irq_return_unit_tb_top;

    localparam int XLEN = 64;
    localparam int NV   = 12;
    localparam logic [63:0] JUNK = 64'hDEAD_BEEF_CAFE_F00D;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ret_valid = 1'b0;
    logic [2:0]      ret_kind = 3'd0;
    logic [XLEN-1:0] srr_addr, srr_state, hsrr_addr, hsrr_state;
    logic [XLEN-1:0] ecrit_addr, ecrit_state, crit_addr, crit_state;
    logic [XLEN-1:0] dbg_addr, dbg_state, mchk_addr, mchk_state;
    logic [XLEN-1:0] link_reg, count_reg;
    logic [XLEN-1:0] pc_o, state_o;
    logic            flush_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_return_unit #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_kind(ret_kind),
        .srr_addr(srr_addr), .srr_state(srr_state),
        .hsrr_addr(hsrr_addr), .hsrr_state(hsrr_state),
        .ecrit_addr(ecrit_addr), .ecrit_state(ecrit_state),
        .crit_addr(crit_addr), .crit_state(crit_state),
        .dbg_addr(dbg_addr), .dbg_state(dbg_state),
        .mchk_addr(mchk_addr), .mchk_state(mchk_state),
        .link_reg(link_reg), .count_reg(count_reg),
        .pc_o(pc_o), .state_o(state_o), .flush_o(flush_o)
    );

    // Vectors run in order: kind-0 entries depend on the state left by the previous one.
    localparam logic [2:0] VK [NV] = '{3'd1, 3'd0, 3'd2, 3'd3, 3'd4, 3'd5,
                                       3'd6, 3'd7, 3'd0, 3'd0, 3'd1, 3'd7};
    localparam logic [63:0] VA [NV] = '{
        64'h8000_0000_1234_5677, 64'h1111_2222_3333_4447, 64'hFFFF_FFFF_0000_0003,
        64'hC000_0000_0000_100B, 64'h0000_0000_0000_2002, 64'h8888_0000_0000_3001,
        64'h0000_0000_ABCD_EF0F, 64'h1234_5678_9ABC_DEF3, 64'h0000_0000_0000_0007,
        64'h0000_0000_0000_0010, 64'h0000_0000_0000_0020, 64'hF000_0000_0000_0001};
    localparam logic [63:0] VS [NV] = '{
        64'h8000_0000_FFFF_FFFF, 64'h0000_0000_7FFF_0001, 64'h0000_1234_783F_0000,
        64'h8000_00AB_FFFF_1234, 64'h0000_0000_FFFF_FFFF, 64'h8000_0000_4000_0000,
        64'hFFFF_FFFF_3FFF_8000, 64'h0000_0000_FFFF_FFFF, 64'h8000_0000_7800_0000,
        64'h0000_0001_0000_0005, 64'h0000_0000_0000_00FF, 64'h8000_0000_1234_5678};
    localparam logic [63:0] EP [NV] = '{
        64'h8000_0000_1234_5674, 64'h0000_0000_3333_4444, 64'h0000_0000_0000_0000,
        64'hC000_0000_0000_1008, 64'h0000_0000_0000_2000, 64'h8888_0000_0000_3000,
        64'h0000_0000_ABCD_EF0C, 64'h0000_0000_9ABC_DEF0, 64'h0000_0000_0000_0004,
        64'h0000_0000_0000_0010, 64'h0000_0000_0000_0020, 64'hF000_0000_0000_0000};
    localparam logic [63:0] ES [NV] = '{
        64'h8000_0000_87C0_FFFF, 64'h8000_0000_07C0_0001, 64'h0000_0000_0000_0000,
        64'h8000_00AB_0000_1234, 64'h0000_0000_C000_FFFF, 64'h8000_0000_4000_0000,
        64'hFFFF_FFFF_0000_8000, 64'h0000_0000_0000_FFFF, 64'h8000_0000_0000_0000,
        64'h8000_0000_0000_0005, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_5678};

    task automatic check64(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check1(input string req, input string what,
                          input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic fill_junk(input logic [63:0] j);
        srr_addr = j;   srr_state = ~j;  hsrr_addr = j ^ 64'h1; hsrr_state = ~j ^ 64'h1;
        ecrit_addr = j ^ 64'h2; ecrit_state = ~j ^ 64'h2; crit_addr = j ^ 64'h3;
        crit_state = ~j ^ 64'h3; dbg_addr = j ^ 64'h4; dbg_state = ~j ^ 64'h4;
        mchk_addr = j ^ 64'h5; mchk_state = ~j ^ 64'h5; link_reg = j ^ 64'h6;
        count_reg = ~j ^ 64'h6;
    endtask

    // R3: place the vector's pair on the source that belongs to its kind
    task automatic load_pair(input logic [2:0] k, input logic [63:0] a, input logic [63:0] s);
        fill_junk(JUNK);
        case (k)
            3'd0, 3'd1: begin srr_addr = a;   srr_state = s;   end
            3'd2:       begin hsrr_addr = a;  hsrr_state = s;  end
            3'd3:       begin ecrit_addr = a; ecrit_state = s; end
            3'd4:       begin crit_addr = a;  crit_state = s;  end
            3'd5:       begin dbg_addr = a;   dbg_state = s;   end
            3'd6:       begin mchk_addr = a;  mchk_state = s;  end
            default:    begin link_reg = a;   count_reg = s;   end
        endcase
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        fill_junk(JUNK);
        repeat (3) @(negedge clk);
        // R1: reset state
        check64("R1", "pc after reset", pc_o, 64'h0);
        check64("R1", "state after reset", state_o, 64'h0);
        check1("R1", "flush after reset", flush_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check1("R7", "flush idle", flush_o, 1'b0);

        // R2..R6: vector table walk
        for (int i = 0; i < NV; i++) begin
            load_pair(VK[i], VA[i], VS[i]);
            ret_kind  = VK[i];
            ret_valid = 1'b1;
            @(negedge clk);
            ret_valid = 1'b0;
            check64("R2/R3/R5/R6", $sformatf("pc vec %0d", i), pc_o, EP[i]);
            check64("R3/R4/R5/R6", $sformatf("state vec %0d", i), state_o, ES[i]);
            check1("R7", $sformatf("flush vec %0d", i), flush_o, 1'b1);
            @(negedge clk);
            check1("R7", $sformatf("flush drop vec %0d", i), flush_o, 1'b0);
        end

        // R8: inputs change with no strobe, outputs hold the last vector's values
        fill_junk(64'h0123_4567_89AB_CDEF);
        ret_kind = 3'd0;
        repeat (3) @(negedge clk);
        check64("R8", "pc held", pc_o, EP[NV-1]);
        check64("R8", "state held", state_o, ES[NV-1]);
        check1("R8", "no flush", flush_o, 1'b0);

        // R7: three back-to-back strobes give a three-cycle pulse
        load_pair(3'd4, 64'h40, 64'h0);
        ret_kind = 3'd4;
        ret_valid = 1'b1;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            check1("R7", $sformatf("chained flush %0d", j), flush_o, 1'b1);
        end
        ret_valid = 1'b0;
        @(negedge clk);
        check1("R7", "chained flush end", flush_o, 1'b0);
        check64("R2", "chained pc", pc_o, 64'h40);

        // R1: reset mid-run clears the registers again
        rst_n = 1'b0;
        @(negedge clk);
        check64("R1", "pc re-reset", pc_o, 64'h0);
        check64("R1", "state re-reset", state_o, 64'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule